// File: doc/BRIEF.md
# Fixed-Priority Shared External Bus Arbiter

This block decides which of several memory controllers drives one shared external memory bus. Each controller raises a request line when it needs the bus and receives a grant line back. Priority is fixed: port 0 ranks highest and the last port ranks lowest, with three ports by default. When the bus is free, the block grants the highest-ranked requester. A grant never moves while its owner keeps requesting.

When a higher-ranked port asks for the bus while a lower-ranked port holds it, the block does not take the grant away. It raises a backoff line toward the owner only, which asks the owner to finish its current access early and drop its request. At the clock edge where the owner's request is seen low, the grant passes straight to the best waiting requester. A preempted port raises its request again after at least one low cycle, and it then competes as a new requester.

The block also routes the granted port's address, write data and data-enable lines onto the shared external pins. When no port holds the bus, every external output is zero.

Top module: `ebus_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `gnt_o` and `backoff_o` are all zero and the external address, data and data-enable are zero.
- R2: At most one grant bit is high at any time. A request to an idle bus with no competitor is granted at the next rising clock edge.
- R3: When the bus is idle and several ports request in the same cycle, the lowest-numbered requesting port (bit 0 of `req_i` is the highest priority) is granted at the next edge.
- R4: While the owning port keeps its request high, its grant stays in place, whatever the other ports request.
- R5: When the owner's request is seen low at a clock edge, its grant drops at that edge. At the same edge the highest-priority other requesting port, if any, is granted.
- R6: While the owner keeps requesting and any port with a lower index also requests, the owner's `backoff_o` bit is high from the next edge. Backoff is set only on the owner's bit. It clears at the edge where the owner's grant is removed.
- R7: `backoff_o[0]` is never asserted.
- R8: The external address, data and data-enable equal the slice of the granted port in the same cycle. Port p's slice occupies bits [p*W +: W] of each packed port bus.
- R9: With no grant active, `ext_den_o`, `ext_addr_o` and `ext_wdata_o` are all zero.
- R10: A port that drops its request and raises it again is arbitrated as a new request. It is not granted ahead of the current owner, and it is not granted ahead of a higher-priority requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_PORTS | Bus request per port, active high |
| gnt_o | output | NUM_PORTS | Registered grant per port, one-hot or zero |
| backoff_o | output | NUM_PORTS | Registered early-release request, owner only |
| port_addr_i | input | NUM_PORTS*ADDR_W | Packed per-port addresses |
| port_wdata_i | input | NUM_PORTS*DATA_W | Packed per-port write data |
| port_den_i | input | NUM_PORTS*DEN_W | Packed per-port data enables |
| ext_addr_o | output | ADDR_W | Shared bus address |
| ext_wdata_o | output | DATA_W | Shared bus write data |
| ext_den_o | output | DEN_W | Shared bus data enable |

## Verification
Grant and backoff are registered, so a request change driven in one cycle appears on `gnt_o` and `backoff_o` after exactly one rising edge. The bench drives inputs on the falling edge and compares results on the next falling edge against a model that advances on the rising edge in between. The bus outputs are combinational from the grant register and the current port inputs. They are therefore checked in the same half-cycle as the grant, using the port data driven for that cycle. Directed sequences cover preemption, handover, re-request and simultaneous requests against fixed expected grants. Random requests that respect the one-cycle-low rule cover the remaining cases.

// File: rtl/ebus_arb_pkg.sv
`timescale 1ns/1ps
package ebus_arb_pkg;

   // Selects how the shared bus multiplexer is built.
   typedef enum logic [0:0] {
      MUX_ANDOR   = 1'b0,   // masked OR of every port slice
      MUX_INDEXED = 1'b1    // one-hot to index, then part-select
   } ebus_mux_e;

   // Width of a port index, at least one bit.
   function automatic int unsigned port_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ebus_prio_pick.sv
`timescale 1ns/1ps
// Fixed-priority picker: lowest index wins. It also reports, for every
// port, whether some higher-priority (lower index) port is requesting.
module ebus_prio_pick #(
   parameter int unsigned NUM_PORTS = 3
) (
   input  logic [NUM_PORTS-1:0] req_i,
   output logic [NUM_PORTS-1:0] win_o,
   output logic [NUM_PORTS-1:0] above_o
);

   // seen[i] is high when any port below index i is requesting
   logic [NUM_PORTS-1:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 1; i < NUM_PORTS; i++) begin : g_seen
         assign seen[i] = seen[i-1] | req_i[i-1];
      end
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_win
         assign win_o[i]   = req_i[i] & ~seen[i];
         assign above_o[i] = seen[i];
      end
   endgenerate

endmodule

// File: rtl/ebus_grant_ctrl.sv
`timescale 1ns/1ps
// Holds the current owner and the registered backoff request.
module ebus_grant_ctrl #(
   parameter int unsigned NUM_PORTS = 3
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [NUM_PORTS-1:0] req_i,
   input  logic [NUM_PORTS-1:0] win_i,
   input  logic [NUM_PORTS-1:0] above_i,
   output logic [NUM_PORTS-1:0] gnt_o,
   output logic [NUM_PORTS-1:0] bo_o
);

   logic [NUM_PORTS-1:0] gnt_q, gnt_d;
   logic [NUM_PORTS-1:0] bo_q, bo_d;
   logic                 owner_keeps;

   always_comb begin
      // the owner keeps the bus as long as its request stays high
      owner_keeps = |(gnt_q & req_i);
      gnt_d       = owner_keeps ? gnt_q : win_i;
      // a freshly picked winner never has a higher requester, so this
      // only fires for an owner that is being preempted
      bo_d        = gnt_d & above_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gnt_q <= '0;
         bo_q  <= '0;
      end else begin
         gnt_q <= gnt_d;
         bo_q  <= bo_d;
      end
   end

   assign gnt_o = gnt_q;
   assign bo_o  = bo_q;

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   p_one_owner_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_o));

   p_idle_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o == '0 && req_i != '0) |=> (gnt_o != '0));

   p_top_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o == '0 && req_i[0]) |=> gnt_o[0]);

   p_top_no_bo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bo_o[0]);

   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
         localparam logic [NUM_PORTS-1:0] HIGHER =
            NUM_PORTS'((64'd1 << i) - 64'd1);

         p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt_o[i] && req_i[i]) |=> gnt_o[i]);

         p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt_o[i] && !req_i[i]) |=> !gnt_o[i]);

         p_bo_raise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt_o[i] && req_i[i] && |(req_i & HIGHER)) |=> bo_o[i]);

         p_bo_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt_o[i] && !req_i[i]) |=> !bo_o[i]);

         p_bo_owner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!gnt_o[i] && !req_i[i]) |=> !bo_o[i]);
      end
   endgenerate

endmodule

// File: rtl/ebus_bus_mux.sv
`timescale 1ns/1ps
// Routes the granted port's address, data and enable to the shared pins.
module ebus_bus_mux #(
   parameter int unsigned           NUM_PORTS = 3,
   parameter int unsigned           ADDR_W    = 24,
   parameter int unsigned           DATA_W    = 32,
   parameter int unsigned           DEN_W     = 4,
   parameter ebus_arb_pkg::ebus_mux_e MUX_KIND = ebus_arb_pkg::MUX_ANDOR
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_PORTS-1:0]        gnt_i,
   input  logic [NUM_PORTS*ADDR_W-1:0] addr_i,
   input  logic [NUM_PORTS*DATA_W-1:0] wdata_i,
   input  logic [NUM_PORTS*DEN_W-1:0]  den_i,
   output logic [ADDR_W-1:0]           addr_o,
   output logic [DATA_W-1:0]           wdata_o,
   output logic [DEN_W-1:0]            den_o
);

   localparam int unsigned IDX_W = ebus_arb_pkg::port_idx_w(NUM_PORTS);

   generate
      if (MUX_KIND == ebus_arb_pkg::MUX_ANDOR) begin : g_andor
         always_comb begin
            addr_o  = '0;
            wdata_o = '0;
            den_o   = '0;
            for (int i = 0; i < NUM_PORTS; i++) begin
               addr_o  = addr_o  | (addr_i[i*ADDR_W +: ADDR_W]  & {ADDR_W{gnt_i[i]}});
               wdata_o = wdata_o | (wdata_i[i*DATA_W +: DATA_W] & {DATA_W{gnt_i[i]}});
               den_o   = den_o   | (den_i[i*DEN_W +: DEN_W]     & {DEN_W{gnt_i[i]}});
            end
         end
      end else begin : g_indexed
         logic [IDX_W-1:0] sel;
         logic             any;
         always_comb begin
            sel = '0;
            for (int i = 0; i < NUM_PORTS; i++) begin
               if (gnt_i[i]) sel = IDX_W'(i);
            end
            any = |gnt_i;
         end
         always_comb begin
            addr_o  = any ? addr_i[sel*ADDR_W +: ADDR_W]  : '0;
            wdata_o = any ? wdata_i[sel*DATA_W +: DATA_W] : '0;
            den_o   = any ? den_i[sel*DEN_W +: DEN_W]     : '0;
         end
      end
   endgenerate

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   p_idle_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_i == '0) |-> (den_o == '0 && addr_o == '0 && wdata_o == '0));

   generate
      for (genvar i = 0; i < NUM_PORTS; i++) begin : g_follow
         p_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            gnt_i[i] |-> (addr_o  == addr_i[i*ADDR_W +: ADDR_W] &&
                          wdata_o == wdata_i[i*DATA_W +: DATA_W] &&
                          den_o   == den_i[i*DEN_W +: DEN_W]));
      end
   endgenerate

endmodule

// File: rtl/ebus_arbiter.sv
`timescale 1ns/1ps
// Fixed-priority shared external bus arbiter with backoff signalling.
module ebus_arbiter #(
   parameter int unsigned             NUM_PORTS = 3,
   parameter int unsigned             ADDR_W    = 24,
   parameter int unsigned             DATA_W    = 32,
   parameter int unsigned             DEN_W     = 4,
   parameter ebus_arb_pkg::ebus_mux_e MUX_KIND  = ebus_arb_pkg::MUX_ANDOR
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_PORTS-1:0]        req_i,
   output logic [NUM_PORTS-1:0]        gnt_o,
   output logic [NUM_PORTS-1:0]        backoff_o,
   input  logic [NUM_PORTS*ADDR_W-1:0] port_addr_i,
   input  logic [NUM_PORTS*DATA_W-1:0] port_wdata_i,
   input  logic [NUM_PORTS*DEN_W-1:0]  port_den_i,
   output logic [ADDR_W-1:0]           ext_addr_o,
   output logic [DATA_W-1:0]           ext_wdata_o,
   output logic [DEN_W-1:0]            ext_den_o
);

   // elaboration-time parameter checks
   generate
      if (NUM_PORTS < 2 || NUM_PORTS > 64) begin : g_bad_ports
         $error("ebus_arbiter: NUM_PORTS must be within 2..64");
      end
      if (ADDR_W < 1 || DATA_W < 1 || DEN_W < 1) begin : g_bad_width
         $error("ebus_arbiter: bus widths must be at least 1");
      end
   endgenerate

   logic [NUM_PORTS-1:0] win;
   logic [NUM_PORTS-1:0] above;
   logic [NUM_PORTS-1:0] gnt;
   logic [NUM_PORTS-1:0] bo;

   ebus_prio_pick #(
      .NUM_PORTS (NUM_PORTS)
   ) u_pick (
      .req_i   (req_i),
      .win_o   (win),
      .above_o (above)
   );

   ebus_grant_ctrl #(
      .NUM_PORTS (NUM_PORTS)
   ) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i),
      .win_i   (win),
      .above_i (above),
      .gnt_o   (gnt),
      .bo_o    (bo)
   );

   ebus_bus_mux #(
      .NUM_PORTS (NUM_PORTS),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .DEN_W     (DEN_W),
      .MUX_KIND  (MUX_KIND)
   ) u_mux (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .gnt_i   (gnt),
      .addr_i  (port_addr_i),
      .wdata_i (port_wdata_i),
      .den_i   (port_den_i),
      .addr_o  (ext_addr_o),
      .wdata_o (ext_wdata_o),
      .den_o   (ext_den_o)
   );

   assign gnt_o     = gnt;
   assign backoff_o = bo;

endmodule

// File: tb/ebus_arbiter_test.sv
`timescale 1ns/1ps
module ebus_arbiter_test;

   localparam int N  = 3;
   localparam int AW = 24;
   localparam int DW = 32;
   localparam int EW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic [N-1:0]    req;
   logic [N-1:0]    gnt, bo;
   logic [N*AW-1:0] addr;
   logic [N*DW-1:0] wdata;
   logic [N*EW-1:0] den;
   logic [AW-1:0]   x_addr;
   logic [DW-1:0]   x_wdata;
   logic [EW-1:0]   x_den;

   logic [AW-1:0] pa [N];
   logic [DW-1:0] pd [N];
   logic [EW-1:0] pe [N];

   ebus_arbiter #(.NUM_PORTS(N), .ADDR_W(AW), .DATA_W(DW), .DEN_W(EW)) uut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .gnt_o(gnt), .backoff_o(bo),
      .port_addr_i(addr), .port_wdata_i(wdata), .port_den_i(den),
      .ext_addr_o(x_addr), .ext_wdata_o(x_wdata), .ext_den_o(x_den)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [N-1:0] m_gnt, m_bo;
   logic [N-1:0] just_dropped;

   // expected next owner from the requirements (R2..R5, R10)
   function automatic logic [N-1:0] next_owner(input logic [N-1:0] cur,
                                                input logic [N-1:0] r);
      if ((cur & r) != '0) return cur;
      for (int p = 0; p < N; p++) if (r[p]) return N'(1) << p;
      return '0;
   endfunction

   // expected backoff (R6, R7)
   function automatic logic [N-1:0] exp_backoff(input logic [N-1:0] own,
                                                input logic [N-1:0] r);
      logic [N-1:0] res = '0;
      for (int p = 0; p < N; p++)
         for (int q = 0; q < p; q++)
            if (own[p] && r[q]) res[p] = 1'b1;
      return res;
   endfunction

   always @(posedge clk) begin : model
      logic [N-1:0] g;
      if (!rst_n) begin
         m_gnt <= '0;
         m_bo  <= '0;
      end else begin
         g = next_owner(m_gnt, req);
         m_gnt <= g;
         m_bo  <= exp_backoff(g, req);
      end
   end

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      logic [AW-1:0] ea = '0;
      logic [DW-1:0] ed = '0;
      logic [EW-1:0] ee = '0;
      for (int p = 0; p < N; p++)
         if (m_gnt[p]) begin ea = pa[p]; ed = pd[p]; ee = pe[p]; end
      check(tag, "gnt", 64'(gnt), 64'(m_gnt));
      check(tag, "backoff", 64'(bo), 64'(m_bo));
      check(tag, "ext_addr", 64'(x_addr), 64'(ea));
      check(tag, "ext_wdata", 64'(x_wdata), 64'(ed));
      check(tag, "ext_den", 64'(x_den), 64'(ee));
   endtask

   task automatic drive(input logic [N-1:0] r);
      req = r;
      for (int p = 0; p < N; p++) begin
         pa[p] = AW'($urandom);
         pd[p] = $urandom;
         pe[p] = EW'($urandom);
         addr[p*AW +: AW]  = pa[p];
         wdata[p*DW +: DW] = pd[p];
         den[p*EW +: EW]   = pe[p];
      end
   endtask

   // drive at a falling edge, pass one rising edge, check at the next falling edge
   task automatic cycle(input logic [N-1:0] r, input string tag);
      drive(r);
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      just_dropped = '0;
      drive('0);
      repeat (3) @(negedge clk);
      check_all("R1 in reset");
      check("R1", "gnt", 64'(gnt), 64'd0);
      rst_n = 1'b1;
      cycle(3'b000, "R1 after reset");
      check("R9", "ext_den idle", 64'(x_den), 64'd0);

      // single request to idle bus
      cycle(3'b100, "R2 single");
      check("R2", "gnt", 64'(gnt), 64'b100);
      cycle(3'b100, "R8 follow");
      check("R8", "ext_addr", 64'(x_addr), 64'(pa[2]));
      // higher port asks: owner gets backoff, keeps grant
      cycle(3'b101, "R6 raise");
      check("R6", "backoff", 64'(bo), 64'b100);
      check("R4", "gnt", 64'(gnt), 64'b100);
      cycle(3'b111, "R4 hold");
      check("R4", "gnt", 64'(gnt), 64'b100);
      // owner drops: grant moves to port 0, backoff clears
      cycle(3'b011, "R5 handover");
      check("R5", "gnt", 64'(gnt), 64'b001);
      check("R6", "backoff clear", 64'(bo), 64'b000);
      cycle(3'b011, "R7 top");
      check("R7", "backoff top", 64'(bo), 64'b000);
      // port 0 drops, port 2 re-requests after its low cycle
      cycle(3'b110, "R5 next");
      check("R5", "gnt", 64'(gnt), 64'b010);
      check("R10", "backoff lower", 64'(bo), 64'b000);
      cycle(3'b110, "R10 waits");
      check("R10", "gnt", 64'(gnt), 64'b010);
      cycle(3'b100, "R10 served");
      check("R10", "gnt", 64'(gnt), 64'b100);
      // port 2 drops and re-requests while port 1 waits
      cycle(3'b010, "R10 drop");
      check("R10", "gnt", 64'(gnt), 64'b010);
      cycle(3'b110, "R10 renew");
      check("R10", "gnt", 64'(gnt), 64'b010);
      cycle(3'b000, "R9 idle");
      check("R9", "ext_addr idle", 64'(x_addr), 64'd0);
      check("R9", "ext_wdata idle", 64'(x_wdata), 64'd0);
      // simultaneous requests to idle bus
      cycle(3'b111, "R3 all");
      check("R3", "gnt", 64'(gnt), 64'b001);
      cycle(3'b000, "R9 idle");
      cycle(3'b110, "R3 pair");
      check("R3", "gnt", 64'(gnt), 64'b010);
      cycle(3'b000, "R9 idle");

      // random controllers obeying the one-cycle-low rule
      for (int c = 0; c < 4000; c++) begin
         logic [N-1:0] r;
         r = req;
         for (int p = 0; p < N; p++) begin
            if (req[p]) begin
               if (gnt[p] && (($urandom % 4) == 0 || (bo[p] && ($urandom % 2) == 0)))
                  r[p] = 1'b0;
            end else if (!just_dropped[p] && ($urandom % 3) == 0) begin
               r[p] = 1'b1;
            end
         end
         just_dropped = req & ~r;
         cycle(r, "R2/R4/R5/R6/R8 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule